// File: doc/BRIEF.md
# Lane-Partitioned Registered ALU with Register File

This block pairs a 64-word register file with a 32-bit arithmetic and logic unit that can work as one wide unit, two 16-bit units or four 8-bit units. In each cycle two register words are read, one by an S-side address and one by an R-side address. Each operand can instead be taken from an external bus. One result word can be written back to a third address in the same cycle. The write data is the ALU result or one of three external buses, and the upper and lower halves of the word can be written independently.

An 8-bit operation code drives the ALU. Its low nibble picks an arithmetic or bitwise function, and its high nibble picks a one-bit shift that is applied to the function's output. When the unit is split, carries stop at unit boundaries and shifts wrap or fill inside each unit. The result word and the per-unit zero and carry flags are captured in registers. They appear on the outputs one clock after the operands are presented.

Top module: `lane_alu_rf`

## Requirements
- R1: Both register reads are combinational from `s_addr` and `r_addr`. A write to `dst_addr` takes effect at the clock edge, and a read in the same cycle still returns the old word. Reset clears every word to zero.
- R2: `wr_en` selects the bits written: 2'b00 writes nothing, 2'b01 writes bits 15:0 only, 2'b10 writes bits 31:16 only, and 2'b11 writes the whole word.
- R3: `wr_src` selects the write data: 0 selects `da_bus`, 1 selects `db_bus`, 2 selects this cycle's shifted ALU result, and 3 selects `ysys_bus`.
- R4: The S operand is the register word when `s_sel` is 0 or 3, `db_bus` when it is 1, and `mq_in` when it is 2. The R operand is the register word when `r_sel` is 0 and `da_bus` when it is 1.
- R5: Low nibble 1 computes R+S+Cn, 2 computes ~R+S+Cn, 3 computes R+~S+Cn, 4 computes S+Cn, 5 computes ~S+Cn, 6 computes R+Cn, and 7 computes ~R+Cn. The carry out of each unit is reported. Low nibbles 0, 8 and F give a zero result with no carry.
- R6: Low nibble 9 computes XOR, A computes AND, B computes OR, C computes NAND, D computes NOR, and E computes ~R AND S. None of these produces a carry.
- R7: `cfg_mode` 0 or 3 selects one 32-bit unit, 1 selects two 16-bit units, and 2 selects four 8-bit units. Each unit takes `cin` as its own carry-in, and no carry crosses a unit boundary.
- R8: The high nibble applies a one-bit shift inside each unit: 0 is arithmetic right (the unit's top bit is kept), 2 is logical right, 4 is left with zero fill, 6 rotates left, and 8 rotates right. Every other value, including F, leaves the result unshifted.
- R9: `y_out` and the flags update at the clock edge after the inputs are applied. Reset clears all of them to zero.
- R10: Flag bit u belongs to unit u, where unit 0 holds the least significant bits. The zero flag is set when the unit's final result is zero. The carry flag is the unit's carry out. Flag bits for units that do not exist in the current mode are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| s_addr | input | 6 | S-side read address |
| r_addr | input | 6 | R-side read address |
| dst_addr | input | 6 | Write address |
| wr_en | input | 2 | Half-word write enables |
| wr_src | input | 2 | Write data select |
| cfg_mode | input | 2 | Unit partition |
| s_sel | input | 2 | S operand select |
| r_sel | input | 1 | R operand select |
| cin | input | 1 | Carry-in for every unit |
| opcode | input | 8 | Shift (high nibble) and function (low nibble) |
| da_bus | input | 32 | External bus A |
| db_bus | input | 32 | External bus B |
| mq_in | input | 32 | Auxiliary S operand |
| ysys_bus | input | 32 | System result bus |
| y_out | output | 32 | Registered result |
| flag_zero | output | 4 | Registered per-unit zero flags |
| flag_carry | output | 4 | Registered per-unit carry flags |

## Verification
The bench builds the block with its default parameters: 32-bit words, a 64-word file and 8-bit minimum lanes. With these values every partition is reachable, and carries and shift fills land on the real 8- and 16-bit boundaries. Directed operands place all-ones bytes next to each unit seam, so that a carry leaking across a seam changes the compared value. A long random run also mixes partial writes with same-cycle reads of the written address.

// File: rtl/lane_alu_pkg.sv
package lane_alu_pkg;
   localparam logic [1:0] WSRC_DA  = 2'd0;
   localparam logic [1:0] WSRC_DB  = 2'd1;
   localparam logic [1:0] WSRC_ALU = 2'd2;
   localparam logic [1:0] WSRC_SYS = 2'd3;

   localparam logic [1:0] CFG_HALF = 2'd1;
   localparam logic [1:0] CFG_QUAD = 2'd2;

   function automatic logic fn_is_arith(input logic [3:0] fn);
      return (fn >= 4'h1) && (fn <= 4'h7);
   endfunction

   function automatic logic fn_is_logic(input logic [3:0] fn);
      return (fn >= 4'h9) && (fn <= 4'hE);
   endfunction
endpackage

// File: rtl/lane_regfile.sv
module lane_regfile #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] s_addr,
   input  logic [ADDR_W-1:0] r_addr,
   output logic [DATA_W-1:0] s_data,
   output logic [DATA_W-1:0] r_data,
   input  logic [ADDR_W-1:0] w_addr,
   input  logic [1:0]        we,
   input  logic [DATA_W-1:0] w_data
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int HW    = DATA_W / 2;

   logic [DATA_W-1:0] mem [DEPTH];

   assign s_data = mem[s_addr];
   assign r_data = mem[r_addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         if (we[0]) mem[w_addr][HW-1:0]      <= w_data[HW-1:0];
         if (we[1]) mem[w_addr][DATA_W-1:HW] <= w_data[DATA_W-1:HW];
      end
   end

   AST_LOW_WRITE_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (we == 2'b01) |=> (mem[$past(w_addr)][DATA_W-1:HW] == $past(mem[w_addr][DATA_W-1:HW]))); // R2
   AST_HIGH_WRITE_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (we == 2'b10) |=> (mem[$past(w_addr)][HW-1:0] == $past(mem[w_addr][HW-1:0]))); // R2
endmodule

// File: rtl/lane_arith.sv
module lane_arith import lane_alu_pkg::*; #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] r_op,
   input  logic [DATA_W-1:0] s_op,
   input  logic [3:0]        fn,
   input  logic              cin,
   input  logic              half,
   input  logic              quad,
   output logic [DATA_W-1:0] res,
   output logic [3:0]        cout
);
   localparam int LW = DATA_W / 4;

   logic              arith, logic_op;
   logic [DATA_W-1:0] a_in, b_in, sum, lres;
   logic [3:0]        chain;

   always_comb begin
      arith    = fn_is_arith(fn);
      logic_op = fn_is_logic(fn);
      a_in     = '0;
      b_in     = '0;
      case (fn)
         4'h1: begin a_in = r_op;  b_in = s_op;  end
         4'h2: begin a_in = ~r_op; b_in = s_op;  end
         4'h3: begin a_in = r_op;  b_in = ~s_op; end
         4'h4: begin               b_in = s_op;  end
         4'h5: begin               b_in = ~s_op; end
         4'h6: begin a_in = r_op;                end
         4'h7: begin a_in = ~r_op;               end
         default: ;
      endcase
   end

   always_comb begin
      case (fn)
         4'h9:    lres = r_op ^ s_op;
         4'hA:    lres = r_op & s_op;
         4'hB:    lres = r_op | s_op;
         4'hC:    lres = ~(r_op & s_op);
         4'hD:    lres = ~(r_op | s_op);
         4'hE:    lres = ~r_op & s_op;
         default: lres = '0;
      endcase
   end

   for (genvar k = 0; k < 4; k++) begin : g_lane
      logic          ci;
      logic          co;
      logic [LW:0]   t;
      if (k == 0) begin : g_first
         assign ci = arith & cin;
      end else begin : g_rest
         assign ci = (quad || (half && k == 2)) ? (arith & cin) : g_lane[k-1].co;
      end
      assign t = {1'b0, a_in[k*LW +: LW]} + {1'b0, b_in[k*LW +: LW]} + {{LW{1'b0}}, ci};
      assign co = t[LW];
      assign sum[k*LW +: LW] = t[LW-1:0];
      assign chain[k] = co;
   end

   assign res  = arith ? sum : (logic_op ? lres : '0);
   assign cout = arith ? chain : 4'b0000;
endmodule

// File: rtl/lane_shift.sv
module lane_shift #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] d,
   input  logic [3:0]        sh,
   input  logic              half,
   input  logic              quad,
   output logic [DATA_W-1:0] q
);
   logic [2:0][DATA_W-1:0] variant;

   for (genvar p = 0; p < 3; p++) begin : g_part
      localparam int UW = DATA_W >> p;
      for (genvar u = 0; u < (1 << p); u++) begin : g_unit
         logic [UW-1:0] seg, o;
         assign seg = d[u*UW +: UW];
         always_comb begin
            case (sh)
               4'h0:    o = {seg[UW-1], seg[UW-1:1]};
               4'h2:    o = {1'b0, seg[UW-1:1]};
               4'h4:    o = {seg[UW-2:0], 1'b0};
               4'h6:    o = {seg[UW-2:0], seg[UW-1]};
               4'h8:    o = {seg[0], seg[UW-1:1]};
               default: o = seg;
            endcase
         end
         assign variant[p][u*UW +: UW] = o;
      end
   end

   assign q = quad ? variant[2] : (half ? variant[1] : variant[0]);
endmodule

// File: rtl/lane_alu_rf.sv
module lane_alu_rf import lane_alu_pkg::*; #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] s_addr,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [ADDR_W-1:0] dst_addr,
   input  logic [1:0]        wr_en,
   input  logic [1:0]        wr_src,
   input  logic [1:0]        cfg_mode,
   input  logic [1:0]        s_sel,
   input  logic              r_sel,
   input  logic              cin,
   input  logic [7:0]        opcode,
   input  logic [DATA_W-1:0] da_bus,
   input  logic [DATA_W-1:0] db_bus,
   input  logic [DATA_W-1:0] mq_in,
   input  logic [DATA_W-1:0] ysys_bus,
   output logic [DATA_W-1:0] y_out,
   output logic [3:0]        flag_zero,
   output logic [3:0]        flag_carry
);
   localparam int LW = DATA_W / 4;

   if ((DATA_W % 8) != 0 || DATA_W < 8) begin : g_bad_width
      $error("lane_alu_rf: DATA_W must be a positive multiple of 8");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("lane_alu_rf: ADDR_W must be at least 1");
   end

   logic              half, quad;
   logic [DATA_W-1:0] rf_s, rf_r, s_op, r_op, alu_res, y_next, w_data;
   logic [3:0]        lane_co, lane_z, zf_next, cf_next;

   assign half = (cfg_mode == CFG_HALF);
   assign quad = (cfg_mode == CFG_QUAD);

   lane_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rf (
      .clk(clk), .rst_n(rst_n), .s_addr(s_addr), .r_addr(r_addr),
      .s_data(rf_s), .r_data(rf_r), .w_addr(dst_addr), .we(wr_en), .w_data(w_data)
   );

   always_comb begin
      case (s_sel)
         2'd1:    s_op = db_bus;
         2'd2:    s_op = mq_in;
         default: s_op = rf_s;
      endcase
      r_op = r_sel ? da_bus : rf_r;
   end

   lane_arith #(.DATA_W(DATA_W)) u_arith (
      .r_op(r_op), .s_op(s_op), .fn(opcode[3:0]), .cin(cin),
      .half(half), .quad(quad), .res(alu_res), .cout(lane_co)
   );

   lane_shift #(.DATA_W(DATA_W)) u_shift (
      .d(alu_res), .sh(opcode[7:4]), .half(half), .quad(quad), .q(y_next)
   );

   always_comb begin
      case (wr_src)
         WSRC_DA:  w_data = da_bus;
         WSRC_DB:  w_data = db_bus;
         WSRC_ALU: w_data = y_next;
         default:  w_data = ysys_bus;
      endcase
   end

   for (genvar k = 0; k < 4; k++) begin : g_lz
      assign lane_z[k] = ~|y_next[k*LW +: LW];
   end

   always_comb begin
      if (quad) begin
         zf_next = lane_z;
         cf_next = lane_co;
      end else if (half) begin
         zf_next = {2'b00, lane_z[3] & lane_z[2], lane_z[1] & lane_z[0]};
         cf_next = {2'b00, lane_co[3], lane_co[1]};
      end else begin
         zf_next = {3'b000, &lane_z};
         cf_next = {3'b000, lane_co[3]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         y_out      <= '0;
         flag_zero  <= '0;
         flag_carry <= '0;
      end else begin
         y_out      <= y_next;
         flag_zero  <= zf_next;
         flag_carry <= cf_next;
      end
   end

   AST_WIDE_UPPER_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (!half && !quad) |=> (flag_zero[3:1] == 3'b000 && flag_carry[3:1] == 3'b000)); // R10
   AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      fn_is_logic(opcode[3:0]) |=> (flag_carry == 4'b0000)); // R6
   AST_PASS_UNSHIFTED: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode[7:4] == 4'hF) |-> (y_next == alu_res)); // R8
   AST_WIDE_ZERO_MATCHES_Y: assert property (@(posedge clk) disable iff (!rst_n)
      (!half && !quad) |=> (flag_zero[0] == (y_out == '0))); // R10
   AST_HALF_ZERO_MATCHES_Y: assert property (@(posedge clk) disable iff (!rst_n)
      half |=> (flag_zero[1] == (y_out[DATA_W-1:DATA_W/2] == '0))); // R10
endmodule

// File: tb/sim_lane_alu_rf.sv
`timescale 1ns/1ps
module sim_lane_alu_rf;
   localparam int CLK_NS = 20;

   logic        clk = 0;
   logic        rst_n = 0;
   logic [5:0]  s_addr = 0, r_addr = 0, dst_addr = 0;
   logic [1:0]  wr_en = 0, wr_src = 0, cfg_mode = 0, s_sel = 0;
   logic        r_sel = 0, cin = 0;
   logic [7:0]  opcode = 8'hFF;
   logic [31:0] da_bus = 0, db_bus = 0, mq_in = 0, ysys_bus = 0;
   logic [31:0] y_out;
   logic [3:0]  flag_zero, flag_carry;

   int n_checks = 0, n_fail = 0;
   bit finished = 0;
   logic [31:0] mdl [64];

   always #(CLK_NS/2) clk = ~clk;

   lane_alu_rf u0 (
      .clk(clk), .rst_n(rst_n), .s_addr(s_addr), .r_addr(r_addr), .dst_addr(dst_addr),
      .wr_en(wr_en), .wr_src(wr_src), .cfg_mode(cfg_mode), .s_sel(s_sel), .r_sel(r_sel),
      .cin(cin), .opcode(opcode), .da_bus(da_bus), .db_bus(db_bus), .mq_in(mq_in),
      .ysys_bus(ysys_bus), .y_out(y_out), .flag_zero(flag_zero), .flag_carry(flag_carry)
   );

   function automatic logic [31:0] model_alu(input logic [7:0] op, input logic [1:0] mode,
         input logic [31:0] r, input logic [31:0] s, input logic c,
         output logic [3:0] z, output logic [3:0] cy);
      int units, uw;
      longint unsigned mask, rv, sv, t, v;
      logic [31:0] out;
      units = (mode == 2'd1) ? 2 : ((mode == 2'd2) ? 4 : 1);
      uw = 32 / units;
      mask = (64'd1 << uw) - 1;
      out = 0; z = 0; cy = 0;
      for (int u = 0; u < units; u++) begin
         rv = (longint'(r) >> (u*uw)) & mask;
         sv = (longint'(s) >> (u*uw)) & mask;
         t = 0;
         case (op[3:0])
            4'h1: t = rv + sv + c;
            4'h2: t = (~rv & mask) + sv + c;
            4'h3: t = rv + (~sv & mask) + c;
            4'h4: t = sv + c;
            4'h5: t = (~sv & mask) + c;
            4'h6: t = rv + c;
            4'h7: t = (~rv & mask) + c;
            4'h9: t = rv ^ sv;
            4'hA: t = rv & sv;
            4'hB: t = rv | sv;
            4'hC: t = ~(rv & sv) & mask;
            4'hD: t = ~(rv | sv) & mask;
            4'hE: t = ~rv & sv & mask;
            default: t = 0;
         endcase
         if (op[3:0] >= 4'h1 && op[3:0] <= 4'h7) cy[u] = t[uw];
         v = t & mask;
         case (op[7:4])
            4'h0: v = (v >> 1) | (v & (64'd1 << (uw-1)));
            4'h2: v = v >> 1;
            4'h4: v = (v << 1) & mask;
            4'h6: v = ((v << 1) | (v >> (uw-1))) & mask;
            4'h8: v = (v >> 1) | ((v & 1) << (uw-1));
            default: ;
         endcase
         z[u] = (v == 0);
         out = out | 32'(v << (u*uw));
      end
      return out;
   endfunction

   task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // One clock with the currently driven inputs; model compared on every clock.
   task automatic step(input string tag);
      logic [31:0] r, s, y, wd;
      logic [3:0]  z, cy;
      r = r_sel ? da_bus : mdl[r_addr];
      case (s_sel)
         2'd1: s = db_bus;
         2'd2: s = mq_in;
         default: s = mdl[s_addr];
      endcase
      y = model_alu(opcode, cfg_mode, r, s, cin, z, cy);
      case (wr_src)
         2'd0: wd = da_bus;
         2'd1: wd = db_bus;
         2'd2: wd = y;
         default: wd = ysys_bus;
      endcase
      @(posedge clk);
      @(negedge clk);
      check(tag, "y_out", y_out, y);
      check(tag, "flag_zero", {28'd0, flag_zero}, {28'd0, z});
      check(tag, "flag_carry", {28'd0, flag_carry}, {28'd0, cy});
      if (wr_en[0]) mdl[dst_addr][15:0]  = wd[15:0];
      if (wr_en[1]) mdl[dst_addr][31:16] = wd[31:16];
   endtask

   task automatic load(input logic [5:0] a, input logic [31:0] v);
      wr_en = 2'b11; wr_src = 2'd0; dst_addr = a; da_bus = v; opcode = 8'hFF;
      step("R3"); // R3: DA bus as write source
      wr_en = 2'b00;
   endtask

   task automatic readback(input logic [5:0] a, input string tag);
      wr_en = 2'b00; s_sel = 2'd0; s_addr = a; opcode = 8'hF4; cin = 0; cfg_mode = 0;
      step(tag);
   endtask

   task automatic op_rr(input logic [7:0] op, input logic [1:0] mode, input logic c,
         input logic [31:0] rv, input logic [31:0] sv, input string tag);
      wr_en = 2'b00; r_sel = 1; s_sel = 2'd1; da_bus = rv; db_bus = sv;
      opcode = op; cfg_mode = mode; cin = c;
      step(tag);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) mdl[i] = 0;
      #(CLK_NS*3);
      @(negedge clk);
      // R9: reset state
      check("R9", "reset y_out", y_out, 32'd0);
      check("R9", "reset flags", {24'd0, flag_zero, flag_carry}, 32'd0);
      rst_n = 1;
      // R1: file cleared by reset
      readback(6'd17, "R1");
      load(6'd1, 32'h1234_5678);
      load(6'd2, 32'hFFFF_00FF);
      load(6'd63, 32'h8001_7FFE);
      readback(6'd1, "R1");
      readback(6'd63, "R1");
      // R1: same-cycle read of the word being written returns the old value
      wr_en = 2'b11; wr_src = 2'd3; ysys_bus = 32'hCAFE_F00D; dst_addr = 6'd1;
      s_sel = 0; s_addr = 6'd1; opcode = 8'hF4; cin = 0; step("R1");
      wr_en = 0; readback(6'd1, "R1");
      // R2: half-word enables
      wr_src = 2'd0; da_bus = 32'hAAAA_BBBB; dst_addr = 6'd2; wr_en = 2'b01; opcode = 8'hFF; step("R2");
      wr_en = 0; readback(6'd2, "R2");
      da_bus = 32'h1111_2222; wr_en = 2'b10; opcode = 8'hFF; step("R2");
      wr_en = 0; readback(6'd2, "R2");
      da_bus = 32'h9999_9999; wr_en = 2'b00; opcode = 8'hFF; step("R2");
      readback(6'd2, "R2");
      // R3: other write sources
      wr_src = 2'd1; db_bus = 32'h0BAD_BEEF; dst_addr = 6'd5; wr_en = 2'b11; opcode = 8'hFF; step("R3");
      wr_en = 0; readback(6'd5, "R3");
      r_sel = 1; s_sel = 2'd1; da_bus = 32'd100; db_bus = 32'd23; opcode = 8'hF1;
      wr_src = 2'd2; dst_addr = 6'd6; wr_en = 2'b11; step("R3");
      wr_en = 0; r_sel = 0; readback(6'd6, "R3");
      // R4: operand selects
      r_sel = 0; r_addr = 6'd63; s_sel = 2'd2; mq_in = 32'h0000_0010; opcode = 8'hF1; cin = 0; step("R4");
      s_sel = 2'd3; s_addr = 6'd5; opcode = 8'hF1; step("R4");
      r_sel = 1; da_bus = 32'h0F0F_0F0F; s_sel = 2'd0; s_addr = 6'd1; opcode = 8'hF9; step("R4");
      // R5: each arithmetic function, with and without carry-in
      for (int f = 0; f < 16; f++) begin
         op_rr({4'hF, 4'(f)}, 2'd0, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001, "R5");
         op_rr({4'hF, 4'(f)}, 2'd0, 1'b1, 32'h7000_0003, 32'h1234_0005, "R5");
      end
      // R6: logic functions
      for (int f = 9; f < 15; f++) op_rr({4'hF, 4'(f)}, 2'd0, 1'b1, 32'hF0F0_1234, 32'hFF00_5678, "R6");
      // R7: carries stop at unit seams
      op_rr(8'hF1, 2'd1, 1'b0, 32'h00FF_FFFF, 32'h0000_0001, "R7");
      op_rr(8'hF1, 2'd2, 1'b1, 32'hFF00_FFFF, 32'h0000_0000, "R7");
      op_rr(8'hF1, 2'd3, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, "R7");
      op_rr(8'hF3, 2'd2, 1'b1, 32'h0102_0304, 32'h0102_0305, "R7");
      op_rr(8'hF3, 2'd1, 1'b1, 32'h0000_0000, 32'h0000_0000, "R7");
      // R8: shifts in every partition
      for (int m = 0; m < 3; m++) begin
         op_rr(8'h0B, 2'(m), 0, 32'h8081_7F01, 0, "R8");
         op_rr(8'h2B, 2'(m), 0, 32'h8081_7F01, 0, "R8");
         op_rr(8'h4B, 2'(m), 0, 32'h8081_7F01, 0, "R8");
         op_rr(8'h6B, 2'(m), 0, 32'h8081_7F01, 0, "R8");
         op_rr(8'h8B, 2'(m), 0, 32'h8081_7F01, 0, "R8");
         op_rr(8'h3B, 2'(m), 0, 32'h8081_7F01, 0, "R8");
      end
      // R10: zero flags per unit, R9: latency covered by every step
      op_rr(8'hFA, 2'd2, 0, 32'hFF00_FF00, 32'h00FF_0F00, "R10");
      op_rr(8'hFA, 2'd1, 0, 32'hFFFF_0000, 32'h0000_FFFF, "R10");
      op_rr(8'hF1, 2'd0, 0, 32'd0, 32'd0, "R9");
      // Mixed random traffic
      for (int i = 0; i < 600; i++) begin
         s_addr = 6'($urandom); r_addr = 6'($urandom); dst_addr = 6'($urandom);
         wr_en = 2'($urandom); wr_src = 2'($urandom); cfg_mode = 2'($urandom);
         s_sel = 2'($urandom); r_sel = 1'($urandom); cin = 1'($urandom);
         opcode = 8'($urandom);
         da_bus = $urandom; db_bus = $urandom; mq_in = $urandom; ysys_bus = $urandom;
         if (i % 4 == 0) dst_addr = s_addr;
         step("R1");
      end
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(CLK_NS*100000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule